// File: doc/BRIEF.md
# Binary and Decimal Add-Subtract Unit

This block is the accumulator arithmetic slice of an 8-bit processor core. It takes the accumulator, an operand and the incoming carry, and produces either an add-with-carry or a subtract-with-borrow result. A decimal-mode input chooses between plain two's-complement arithmetic and packed BCD arithmetic, where each byte holds two decimal digits. Instruction decode, the logical operations and the status register live elsewhere. The surrounding core latches the four flag outputs itself.

In decimal mode the flags follow an older processor's behaviour, and software written for that processor depends on it. For decimal addition, zero comes from the uncorrected binary sum. Negative and overflow are taken from the upper digit sum before its +6 correction. For decimal subtraction, every flag comes from the binary difference, and only the result byte is digit-corrected.

Operands are captured when `in_valid` is high. The result and flags appear on the next clock edge with `out_valid` high. When `in_valid` is low, the outputs hold their last value and `out_valid` is low. A parameter can turn the output register into a purely combinational path.

Top module: `bcd_addsub_unit`

## Requirements
- R1: Binary add (`op_sub`=0, `dec_mode`=0) gives result = (acc + opnd + carry_in) mod 256, and carry_out is 1 exactly when that sum exceeds 255.
- R2: In binary mode (both operations), zero_out is 1 when the 8-bit result is 0 and neg_out equals result bit 7. For binary add, ovf_out is 1 when acc and opnd have the same bit 7 and the result's bit 7 differs from it.
- R3: Decimal add (`dec_mode`=1) sums the low digits plus carry_in and adds 6 when that sum exceeds 9. The high digit sum then gets one extra when the corrected low sum exceeds 15.
- R4: In decimal add, zero_out is 1 when (acc + opnd + carry_in) mod 256 is 0, whatever the corrected result.
- R5: In decimal add, neg_out is bit 3 of the high digit sum before correction. ovf_out is 1 when that bit differs from acc bit 7 and acc and opnd have equal bit 7.
- R6: In decimal add, the high digit sum gets +6 when it exceeds 9. carry_out is 1 when the corrected high value exceeds 15. The result is the corrected high digit above the low 4 bits of the corrected low sum. With valid BCD inputs, both result digits are at most 9.
- R7: Subtract (`op_sub`=1) uses borrow = NOT carry_in. carry_out is 1 exactly when acc >= opnd + borrow. ovf_out is 1 when acc and opnd differ in bit 7 and the binary difference's bit 7 differs from acc bit 7. In binary mode the result is (acc - opnd - borrow) mod 256.
- R8: In decimal subtract, carry_out, ovf_out, zero_out and neg_out are those of the binary difference, not of the corrected result.
- R9: In decimal subtract, a negative low digit difference (including the borrow) has 6 subtracted and takes 1 from the high digit difference. A negative high difference then has 6 subtracted. The result is the two low nibbles, high above low.
- R10: A capture with `in_valid`=1 shows up on the outputs one clock later with `out_valid`=1. In a cycle after `in_valid`=0, `out_valid` is 0 and result and flags keep their values.
- R11: While `rst_n` is low and after it is released, before any capture, `out_valid`, result and all four flags are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Capture strobe for the operands and controls |
| op_sub | input | 1 | 0 = add with carry, 1 = subtract with borrow |
| dec_mode | input | 1 | 1 = packed BCD arithmetic |
| acc_in | input | 8 | Accumulator operand |
| opnd_in | input | 8 | Second operand |
| carry_in | input | 1 | Incoming carry (inverted borrow for subtract) |
| out_valid | output | 1 | Result of the previous capture is present |
| result | output | 8 | Result byte |
| carry_out | output | 1 | Carry / no-borrow flag |
| ovf_out | output | 1 | Signed overflow flag |
| zero_out | output | 1 | Zero flag |
| neg_out | output | 1 | Negative flag |

## Verification
The digit-range checks only claim anything when both operands hold valid BCD digits, because the decimal correction gives no digit guarantee for nibbles above 9. The stimulus therefore sweeps all valid BCD pairs separately from a sample of invalid-digit pairs in decimal mode. The carry comparisons and the pipeline properties assume only that inputs are stable around the capturing edge. The bench meets this by changing inputs on the falling edge.

// File: rtl/au_pkg.sv
package au_pkg;

  localparam int unsigned DATA_W = 8;
  localparam int unsigned NIB_W  = DATA_W / 2;

  typedef logic [DATA_W-1:0] byte_t;
  typedef logic [NIB_W-1:0]  nib_t;

  // result byte plus flags, flag order c, v, z, n
  typedef struct packed {
    byte_t res;
    logic  c;
    logic  v;
    logic  z;
    logic  n;
  } au_out_t;

  function automatic logic f_is_digit(input nib_t d);
    return d <= nib_t'(9);
  endfunction

  function automatic logic f_bcd_byte(input byte_t b);
    return f_is_digit(b[DATA_W-1:NIB_W]) && f_is_digit(b[NIB_W-1:0]);
  endfunction

  function automatic logic f_is_zero(input byte_t b);
    return b == '0;
  endfunction

  // same operand signs, result sign differs
  function automatic logic f_add_ovf(input logic sa, input logic sb, input logic sr);
    return (sa ~^ sb) & (sa ^ sr);
  endfunction

  // operand signs differ, result sign differs from accumulator
  function automatic logic f_sub_ovf(input logic sa, input logic sb, input logic sr);
    return (sa ^ sb) & (sa ^ sr);
  endfunction

  // +6 correction on an add digit sum above nine
  function automatic logic [NIB_W+1:0] f_add_fix(input logic [NIB_W:0] s);
    logic [NIB_W+1:0] w;
    w = {1'b0, s};
    if (s > (NIB_W+1)'(9)) w = w + (NIB_W+2)'(6);
    return w;
  endfunction

  // -6 correction on a negative subtract digit difference
  function automatic nib_t f_sub_fix(input logic [NIB_W:0] d);
    nib_t w;
    w = d[NIB_W-1:0];
    if (d[NIB_W]) w = w - nib_t'(6);
    return w;
  endfunction

endpackage

// File: rtl/au_add_path.sv
module au_add_path
  import au_pkg::*;
(
  input  byte_t   a_i,
  input  byte_t   b_i,
  input  logic    ci_i,
  input  logic    dec_i,
  output au_out_t y_o
);

  localparam int unsigned SW = DATA_W + 1;
  localparam int unsigned DW = NIB_W + 1;

  logic [SW-1:0]    bin_sum;
  logic [DW-1:0]    lo_sum;
  logic [DW:0]      lo_fix;
  logic             lo_spill;
  logic [DW-1:0]    hi_raw;
  logic [DW:0]      hi_fix;
  au_out_t          bin_y;
  au_out_t          dec_y;

  always_comb begin
    bin_sum  = {1'b0, a_i} + {1'b0, b_i} + SW'(ci_i);
    lo_sum   = {1'b0, a_i[NIB_W-1:0]} + {1'b0, b_i[NIB_W-1:0]} + DW'(ci_i);
    lo_fix   = f_add_fix(lo_sum);
    lo_spill = lo_fix > (DW+1)'(15);
    hi_raw   = {1'b0, a_i[DATA_W-1:NIB_W]} + {1'b0, b_i[DATA_W-1:NIB_W]} + DW'(lo_spill);
    hi_fix   = f_add_fix(hi_raw);
  end

  always_comb begin
    bin_y.res = bin_sum[DATA_W-1:0];
    bin_y.c   = bin_sum[DATA_W];
    bin_y.v   = f_add_ovf(a_i[DATA_W-1], b_i[DATA_W-1], bin_sum[DATA_W-1]);
    bin_y.z   = f_is_zero(bin_sum[DATA_W-1:0]);
    bin_y.n   = bin_sum[DATA_W-1];

    dec_y.res = {hi_fix[NIB_W-1:0], lo_fix[NIB_W-1:0]};
    dec_y.c   = hi_fix > (DW+1)'(15);
    dec_y.v   = f_add_ovf(a_i[DATA_W-1], b_i[DATA_W-1], hi_raw[NIB_W-1]);
    dec_y.z   = f_is_zero(bin_sum[DATA_W-1:0]);
    dec_y.n   = hi_raw[NIB_W-1];
  end

  assign y_o = dec_i ? dec_y : bin_y;

  always_comb begin
    AST_ADD_CARRY_CMP: assert (bin_y.c == ({1'b0, bin_y.res} < ({1'b0, a_i} + SW'(ci_i)))) else $error("add carry mismatch"); // R1
    if (f_bcd_byte(a_i) && f_bcd_byte(b_i)) begin
      AST_ADD_BCD_RANGE: assert (f_bcd_byte(dec_y.res)) else $error("decimal add digit out of range"); // R6
    end
  end

endmodule

// File: rtl/au_sub_path.sv
module au_sub_path
  import au_pkg::*;
(
  input  byte_t   a_i,
  input  byte_t   b_i,
  input  logic    ci_i,
  input  logic    dec_i,
  output au_out_t y_o
);

  localparam int unsigned SW = DATA_W + 1;
  localparam int unsigned DW = NIB_W + 1;

  logic             borrow;
  logic [SW-1:0]    bin_diff;
  logic [DW-1:0]    lo_diff;
  logic [DW-1:0]    hi_diff;
  logic [DW-1:0]    hi_borrowed;
  nib_t             lo_adj;
  nib_t             hi_adj;
  au_out_t          flags_y;

  always_comb begin
    borrow      = ~ci_i;
    bin_diff    = {1'b0, a_i} - {1'b0, b_i} - SW'(borrow);
    lo_diff     = {1'b0, a_i[NIB_W-1:0]} - {1'b0, b_i[NIB_W-1:0]} - DW'(borrow);
    hi_diff     = {1'b0, a_i[DATA_W-1:NIB_W]} - {1'b0, b_i[DATA_W-1:NIB_W]};
    lo_adj      = f_sub_fix(lo_diff);
    hi_borrowed = lo_diff[NIB_W] ? hi_diff - DW'(1) : hi_diff;
    hi_adj      = f_sub_fix(hi_borrowed);
  end

  // flags are common to both modes
  always_comb begin
    flags_y.res = bin_diff[DATA_W-1:0];
    flags_y.c   = ~bin_diff[DATA_W];
    flags_y.v   = f_sub_ovf(a_i[DATA_W-1], b_i[DATA_W-1], bin_diff[DATA_W-1]);
    flags_y.z   = f_is_zero(bin_diff[DATA_W-1:0]);
    flags_y.n   = bin_diff[DATA_W-1];
  end

  always_comb begin
    y_o = flags_y;
    if (dec_i) y_o.res = {hi_adj, lo_adj};
  end

  always_comb begin
    AST_SUB_CARRY_CMP: assert (flags_y.c == ({1'b0, a_i} >= ({1'b0, b_i} + SW'(borrow)))) else $error("subtract carry mismatch"); // R7
    if (dec_i && f_bcd_byte(a_i) && f_bcd_byte(b_i)) begin
      AST_SUB_BCD_RANGE: assert (f_bcd_byte(y_o.res)) else $error("decimal subtract digit out of range"); // R9
    end
  end

endmodule

// File: rtl/au_out_stage.sv
module au_out_stage
  import au_pkg::*;
#(
  parameter bit REG_OUT = 1'b1
) (
  input  logic    clk,
  input  logic    rst_n,
  input  logic    in_valid,
  input  au_out_t d_i,
  output logic    out_valid,
  output au_out_t q_o
);

  generate
    if (REG_OUT) begin : g_reg
      au_out_t q_r;
      logic    v_r;

      always_ff @(posedge clk) begin
        if (!rst_n) begin
          q_r <= '0;
          v_r <= 1'b0;
        end else begin
          v_r <= in_valid;
          if (in_valid) q_r <= d_i;
        end
      end

      assign q_o       = q_r;
      assign out_valid = v_r;

      AST_VALID_PIPE: assert property (@(posedge clk) disable iff (!rst_n) in_valid |=> out_valid) else $error("valid not forwarded"); // R10
      AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n) !in_valid |=> (!out_valid && $stable(q_o))) else $error("outputs moved while idle"); // R10
    end else begin : g_comb
      logic unused_clk;
      assign unused_clk = clk ^ rst_n;
      assign q_o        = in_valid ? d_i : '0;
      assign out_valid  = in_valid;
    end
  endgenerate

endmodule

// File: rtl/bcd_addsub_unit.sv
module bcd_addsub_unit
  import au_pkg::*;
#(
  parameter bit REG_OUT = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic              op_sub,
  input  logic              dec_mode,
  input  logic [DATA_W-1:0] acc_in,
  input  logic [DATA_W-1:0] opnd_in,
  input  logic              carry_in,
  output logic              out_valid,
  output logic [DATA_W-1:0] result,
  output logic              carry_out,
  output logic              ovf_out,
  output logic              zero_out,
  output logic              neg_out
);

  au_out_t add_y;
  au_out_t sub_y;
  au_out_t sel_y;
  au_out_t q;

  au_add_path u_add (
    .a_i   (acc_in),
    .b_i   (opnd_in),
    .ci_i  (carry_in),
    .dec_i (dec_mode),
    .y_o   (add_y)
  );

  au_sub_path u_sub (
    .a_i   (acc_in),
    .b_i   (opnd_in),
    .ci_i  (carry_in),
    .dec_i (dec_mode),
    .y_o   (sub_y)
  );

  assign sel_y = op_sub ? sub_y : add_y;

  au_out_stage #(.REG_OUT(REG_OUT)) u_out (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .d_i       (sel_y),
    .out_valid (out_valid),
    .q_o       (q)
  );

  assign result    = q.res;
  assign carry_out = q.c;
  assign ovf_out   = q.v;
  assign zero_out  = q.z;
  assign neg_out   = q.n;

  generate
    if (REG_OUT) begin : g_chk
      AST_BIN_ZERO_NEG: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !$past(dec_mode)) |-> ((zero_out == (result == '0)) && (neg_out == result[DATA_W-1])))
        else $error("binary zero/negative mismatch"); // R2
    end
  endgenerate

endmodule

// File: tb/bcd_addsub_unit_tb.sv
`timescale 1ns/1ps
module bcd_addsub_unit_tb;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       in_valid = 1'b0;
  logic       op_sub = 1'b0;
  logic       dec_mode = 1'b0;
  logic [7:0] acc_in = 8'h00;
  logic [7:0] opnd_in = 8'h00;
  logic       carry_in = 1'b0;
  logic       out_valid;
  logic [7:0] result;
  logic       carry_out, ovf_out, zero_out, neg_out;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  bcd_addsub_unit u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_sub(op_sub),
    .dec_mode(dec_mode), .acc_in(acc_in), .opnd_in(opnd_in), .carry_in(carry_in),
    .out_valid(out_valid), .result(result), .carry_out(carry_out),
    .ovf_out(ovf_out), .zero_out(zero_out), .neg_out(neg_out)
  );

  // reference model, written with plain integers; packs {res, c, v, z, n}
  function automatic logic [11:0] model(int a, int b, int c, int dec, int sub);
    int lo, hi, r, t, cy, ov, zf, nf;
    if (!sub) begin
      t = a + b + c;
      zf = ((t % 256) == 0);
      if (!dec) begin
        r = t % 256; cy = (t > 255);
        ov = (((a >= 128) == (b >= 128)) && ((a >= 128) != (r >= 128)));
        nf = (r >= 128);
      end else begin
        lo = (a % 16) + (b % 16) + c;
        if (lo > 9) lo = lo + 6;
        hi = (a / 16) + (b / 16) + ((lo > 15) ? 1 : 0);
        nf = ((hi / 8) % 2);
        ov = ((nf != (a >= 128 ? 1 : 0)) && ((a >= 128) == (b >= 128)));
        if (hi > 9) hi = hi + 6;
        cy = (hi > 15);
        r = (hi % 16) * 16 + (lo % 16);
      end
    end else begin
      t = a - b - (1 - c);
      cy = (t >= 0);
      r = (t + 256) % 256;
      ov = (((a >= 128) != (b >= 128)) && ((a >= 128) != (r >= 128)));
      zf = (r == 0);
      nf = (r >= 128);
      if (dec) begin
        lo = (a % 16) - (b % 16) - (1 - c);
        hi = (a / 16) - (b / 16);
        if (lo < 0) begin lo = lo - 6; hi = hi - 1; end
        if (hi < 0) hi = hi - 6;
        r = ((hi + 32) % 16) * 16 + ((lo + 32) % 16);
      end
    end
    return {r[7:0], cy[0], ov[0], zf[0], nf[0]};
  endfunction

  // drive at a falling edge, check at the next falling edge
  task automatic run_op(string tag, logic [7:0] a, logic [7:0] b, logic c,
                        logic dec, logic sub, logic [11:0] exp);
    acc_in = a; opnd_in = b; carry_in = c; dec_mode = dec; op_sub = sub; in_valid = 1'b1;
    @(negedge clk);
    checks++;
    if (!out_valid || {result, carry_out, ovf_out, zero_out, neg_out} !== exp) begin
      errors++;
      $display("FAIL %s a=%02h b=%02h c=%0d dec=%0d sub=%0d: got v=%0d res=%02h cvzn=%04b, expected res=%02h cvzn=%04b",
               tag, a, b, c, dec, sub, out_valid, result,
               {carry_out, ovf_out, zero_out, neg_out}, exp[11:4], exp[3:0]);
    end
  endtask

  task automatic model_op(string tag, int a, int b, int c, int dec, int sub);
    run_op(tag, a[7:0], b[7:0], c[0], dec[0], sub[0], model(a, b, c, dec, sub));
  endtask

  task automatic t_reset;
    checks++;
    if (out_valid !== 1'b0 || result !== 8'h00 || {carry_out, ovf_out, zero_out, neg_out} !== 4'b0000) begin
      errors++;
      $display("FAIL R11 reset: got v=%0d res=%02h flags=%04b, expected 0 00 0000",
               out_valid, result, {carry_out, ovf_out, zero_out, neg_out});
    end
  endtask

  task automatic t_binary_add;
    run_op("R1 R2 signed overflow", 8'h50, 8'h50, 1'b0, 1'b0, 1'b0, {8'hA0, 4'b0101});
    run_op("R1 R2 wrap to zero",    8'hFF, 8'h01, 1'b0, 1'b0, 1'b0, {8'h00, 4'b1010});
    run_op("R1 carry in",           8'h12, 8'h34, 1'b1, 1'b0, 1'b0, {8'h47, 4'b0000});
  endtask

  task automatic t_decimal_add;
    run_op("R3 low digit fix",       8'h09, 8'h01, 1'b0, 1'b1, 1'b0, {8'h10, 4'b0000});
    run_op("R4 R5 R6 99+1",          8'h99, 8'h01, 1'b0, 1'b1, 1'b0, {8'h00, 4'b1001});
    run_op("R5 raw high digit flags", 8'h79, 8'h00, 1'b1, 1'b1, 1'b0, {8'h80, 4'b0101});
    run_op("R4 R6 binary zero sum",  8'h80, 8'h80, 1'b0, 1'b1, 1'b0, {8'h60, 4'b1110});
  endtask

  task automatic t_subtract;
    run_op("R7 binary underflow",   8'h00, 8'h01, 1'b1, 1'b0, 1'b1, {8'hFF, 4'b0001});
    run_op("R7 signed overflow",    8'h80, 8'h01, 1'b1, 1'b0, 1'b1, {8'h7F, 4'b1100});
    run_op("R7 borrow from carry",  8'h05, 8'h05, 1'b0, 1'b0, 1'b1, {8'hFF, 4'b0001});
    run_op("R9 decimal digit borrow", 8'h10, 8'h01, 1'b1, 1'b1, 1'b1, {8'h09, 4'b1000});
    run_op("R8 R9 decimal wrap",    8'h00, 8'h01, 1'b1, 1'b1, 1'b1, {8'h99, 4'b0001});
    run_op("R8 decimal zero",       8'h05, 8'h05, 1'b1, 1'b1, 1'b1, {8'h00, 4'b1010});
  endtask

  task automatic t_hold;
    logic [11:0] held;
    run_op("R10 capture", 8'h23, 8'h45, 1'b0, 1'b0, 1'b0, {8'h68, 4'b0000});
    held = {result, carry_out, ovf_out, zero_out, neg_out};
    in_valid = 1'b0; acc_in = 8'hFF; opnd_in = 8'hFF; carry_in = 1'b1; op_sub = 1'b1;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      checks++;
      if (out_valid !== 1'b0 || {result, carry_out, ovf_out, zero_out, neg_out} !== held) begin
        errors++;
        $display("FAIL R10 idle hold: got v=%0d %03h, expected v=0 %03h",
                 out_valid, {result, carry_out, ovf_out, zero_out, neg_out}, held);
      end
    end
  endtask

  task automatic t_sweep_bcd;
    for (int hi_a = 0; hi_a < 10; hi_a++)
      for (int lo_a = 0; lo_a < 10; lo_a++)
        for (int hi_b = 0; hi_b < 10; hi_b++)
          for (int lo_b = 0; lo_b < 10; lo_b++)
            for (int k = 0; k < 4; k++)
              model_op(k[1] ? "R8 R9 bcd sweep" : "R3 R4 R5 R6 bcd sweep",
                       hi_a * 16 + lo_a, hi_b * 16 + lo_b, k % 2, 1, k / 2);
  endtask

  task automatic t_sweep_binary;
    for (int a = 0; a < 256; a++)
      for (int b = 0; b < 256; b += 5)
        for (int k = 0; k < 4; k++)
          model_op(k[1] ? "R7 binary sweep" : "R1 R2 binary sweep", a, b, k % 2, 0, k / 2);
  endtask

  task automatic t_sweep_bad_digits;
    for (int a = 0; a < 256; a++)
      for (int b = 3; b < 256; b += 17)
        for (int k = 0; k < 4; k++)
          model_op("R5 R9 non-bcd decimal", a, b, k % 2, 1, k / 2);
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_binary_add();
    t_decimal_add();
    t_subtract();
    t_hold();
    t_sweep_bcd();
    t_sweep_binary();
    t_sweep_bad_digits();
    in_valid = 1'b0;
    @(negedge clk);
    finish_run();
  end

  initial begin
    repeat (190000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: run did not complete, got timeout, expected completion");
    finish_run();
  end

endmodule